// File: doc/BRIEF.md
# Secure Low-Power Seconds Counter

This block keeps wall-clock time for a chip that spends long periods asleep. It holds a counter that steps once per slow-clock period. The upper 32 bits of that counter are whole seconds and the lower bits are a binary fraction of a second. It also holds a seconds alarm, a monotonic event counter that can only be incremented, and one interrupt line.

Software reaches the block through a simple 32-bit register port: address, write strobe, write data and combinational read data. The slow domain appears inside the bus clock domain as a one-cycle `slow_tick` strobe, one per slow-clock period. It is produced upstream from the 32.768 kHz oscillator. Writes to registers in the slow domain are not applied at once. They wait for a fixed number of slow ticks, and software can watch that wait through a pending flag and a done flag.

After reset the counter is frozen. Software must first load a fixed key into the glitch-guard register. It then requests the exit from the init state, and after that the exit from the non-valid state. Only in the valid state does time advance.

Top module: `lprtc_top`

## Requirements
- R1: After reset, time, alarm, monotonic counter and control all read zero and `irq` is low. The status register at 0x14 reads bit 1 = 1 (guard key absent), bits 11:10 = the `SEC_MODE` parameter (0 low, 1 medium, 2 high), and every other bit 0.
- R2: While the guard register at 0x18 differs from 0x41736166, status bit 1 reads 1 and both state-exit requests are ignored. Once the key is loaded, bit 1 reads 0.
- R3: A control write (0x10) with bit 15 set, applied in the init state with the key present, moves the block to the non-valid state and sets status bit 15.
- R4: A control write with bits 14 and 3 both set, applied in the non-valid state with the key present, moves the block to the valid state and sets status bit 14. The counter advances by one per `slow_tick` only in the valid state while control bit 3 is set. Seconds read at 0x00, and the fraction reads at 0x04 bits 31 down to 32-`FRAC_W`.
- R5: A write to 0x00, 0x08, 0x0C, 0x10 or 0x18 takes effect on the `SYNC_TICKS`-th `slow_tick` after it is accepted. Bit 21 of 0x1C reads 1 during that wait. Bit 19 of 0x1C sets when the write takes effect and is cleared by writing 1 to it.
- R6: A write to any of those registers that arrives while a previous one is still pending is dropped.
- R7: A write to 0x00 loads the seconds and zeroes the fraction. While control bit 8 is set, writes to 0x00 are ignored.
- R8: While control bit 4 is set, status bit 3 sets when the counter steps into a new second equal to the alarm register (0x08). `irq` is high exactly while status bit 3 and control bit 7 are both set.
- R9: Each write to 0x0C increments the monotonic counter. The write is ignored while control bit 9 is set. Wrapping from all ones to zero sets status bit 4.
- R10: When the counter wraps from all ones to zero, status bit 5 sets.
- R11: Status bits 3, 4, 5, 14 and 15 are cleared by writing 1 to them. Writing all ones clears every flag. A flag that is set and cleared in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle strobe per slow-clock period |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Alarm interrupt |

## Verification
The bench builds the block with a 3-bit fraction and a 4-bit monotonic counter, keeps `SYNC_TICKS` at 3, and sets the security mode to medium. The 3-bit fraction makes a second only eight slow ticks long, so seconds roll over, alarms fire and a load of 0xFFFFFFFF wraps the time counter within a few dozen cycles. The 4-bit monotonic counter wraps after sixteen writes. With these sizes every flag and the lock bits can be exercised, and the handshake runs at its default depth.

// File: rtl/lprtc_pkg.sv
package lprtc_pkg;
   localparam logic [31:0] GUARD_KEY = 32'h4173_6166;

   localparam logic [7:0] OFS_SEC   = 8'h00;
   localparam logic [7:0] OFS_FRAC  = 8'h04;
   localparam logic [7:0] OFS_ALARM = 8'h08;
   localparam logic [7:0] OFS_MONO  = 8'h0C;
   localparam logic [7:0] OFS_CTRL  = 8'h10;
   localparam logic [7:0] OFS_STAT  = 8'h14;
   localparam logic [7:0] OFS_GUARD = 8'h18;
   localparam logic [7:0] OFS_HSHK  = 8'h1C;

   localparam int CB_RUN   = 3;
   localparam int CB_ARM   = 4;
   localparam int CB_IE    = 7;
   localparam int CB_LOCKT = 8;
   localparam int CB_LOCKM = 9;
   localparam int CB_NVX   = 14;
   localparam int CB_INX   = 15;

   localparam int SB_NOKEY = 1;
   localparam int SB_ALM   = 3;
   localparam int SB_MWRAP = 4;
   localparam int SB_TWRAP = 5;
   localparam int SB_MODE  = 10;
   localparam int SB_NVX   = 14;
   localparam int SB_INX   = 15;

   localparam int HB_DONE  = 19;
   localparam int HB_PEND  = 21;

   typedef enum logic [1:0] {
      ST_INIT     = 2'd0,
      ST_NONVALID = 2'd1,
      ST_VALID    = 2'd2
   } lp_state_e;
endpackage

// File: rtl/lprtc_wr_sync.sv
module lprtc_wr_sync #(
   parameter int AW         = 6,
   parameter int SYNC_TICKS = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          slow_tick,
   input  logic          req,
   input  logic          done_clr,
   input  logic [AW-1:0] req_addr,
   input  logic [31:0]   req_data,
   output logic          pend,
   output logic          done,
   output logic          apply,
   output logic [AW-1:0] ap_addr,
   output logic [31:0]   ap_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend    <= 1'b0;
         done    <= 1'b0;
         ap_addr <= '0;
         ap_data <= '0;
      end else begin
         if (req && !pend) begin
            pend    <= 1'b1;
            ap_addr <= req_addr;
            ap_data <= req_data;
         end else if (apply) begin
            pend <= 1'b0;
         end
         done <= apply | (done & ~done_clr);
      end
   end

   generate
      if (SYNC_TICKS == 1) begin : g_direct
         assign apply = pend & slow_tick;
      end else begin : g_count
         localparam int CW = $clog2(SYNC_TICKS);
         logic [CW-1:0] ticks_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         ticks_q <= '0;
            else if (!pend)     ticks_q <= '0;
            else if (slow_tick) ticks_q <= ticks_q + CW'(1);
         end
         assign apply = pend & slow_tick & (ticks_q == CW'(SYNC_TICKS - 1));
      end
   endgenerate
endmodule

// File: rtl/lprtc_fsm.sv
module lprtc_fsm
   import lprtc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ctrl_wr,
   input  logic      req_init_exit,
   input  logic      req_nv_exit,
   input  logic      req_run,
   input  logic      guard_ok,
   output lp_state_e state,
   output logic      init_exit_evt,
   output logic      nv_exit_evt
);
   always_comb begin
      init_exit_evt = ctrl_wr && guard_ok && (state == ST_INIT) && req_init_exit;
      nv_exit_evt   = ctrl_wr && guard_ok && (state == ST_NONVALID) &&
                      req_nv_exit && req_run;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             state <= ST_INIT;
      else if (init_exit_evt) state <= ST_NONVALID;
      else if (nv_exit_evt)   state <= ST_VALID;
   end
endmodule

// File: rtl/lprtc_timer.sv
module lprtc_timer #(
   parameter int FRAC_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  logic              load,
   input  logic [31:0]       load_secs,
   input  logic [31:0]       alarm_secs,
   input  logic              arm,
   output logic [31:0]       secs,
   output logic [FRAC_W-1:0] frac,
   output logic              alarm_evt,
   output logic              wrap_evt
);
   localparam int TW = 32 + FRAC_W;

   logic [TW-1:0] cnt_q;
   logic [TW-1:0] cnt_nx;

   assign cnt_nx = cnt_q + TW'(1);
   assign secs   = cnt_q[TW-1:FRAC_W];
   assign frac   = cnt_q[FRAC_W-1:0];

   always_comb begin
      alarm_evt = advance && !load && arm &&
                  (cnt_nx[FRAC_W-1:0] == '0) && (cnt_nx[TW-1:FRAC_W] == alarm_secs);
      wrap_evt  = advance && !load && (&cnt_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (load)    cnt_q <= {load_secs, {FRAC_W{1'b0}}};
      else if (advance) cnt_q <= cnt_nx;
   end
endmodule

// File: rtl/lprtc_top.sv
module lprtc_top
   import lprtc_pkg::*;
#(
   parameter int FRAC_W     = 15,
   parameter int MONO_W     = 32,
   parameter int SYNC_TICKS = 3,
   parameter int AW         = 6,
   parameter int SEC_MODE   = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          slow_tick,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [31:0]   bus_wdata,
   output logic [31:0]   bus_rdata,
   output logic          irq
);
   generate
      if (FRAC_W < 1 || FRAC_W > 32) begin : g_bad_frac
         $error("lprtc_top: FRAC_W must lie in 1..32");
      end
      if (MONO_W < 1 || MONO_W > 32) begin : g_bad_mono
         $error("lprtc_top: MONO_W must lie in 1..32");
      end
      if (SYNC_TICKS < 1) begin : g_bad_sync
         $error("lprtc_top: SYNC_TICKS must be at least 1");
      end
      if (AW < 5 || AW > 8) begin : g_bad_aw
         $error("lprtc_top: AW must lie in 5..8");
      end
      if (SEC_MODE < 0 || SEC_MODE > 2) begin : g_bad_mode
         $error("lprtc_top: SEC_MODE must be 0, 1 or 2");
      end
   endgenerate

   localparam logic [1:0] MODE_BITS = 2'(SEC_MODE);

   function automatic logic is_slow_reg(input logic [AW-1:0] a);
      return (a == OFS_SEC[AW-1:0])  || (a == OFS_ALARM[AW-1:0]) ||
             (a == OFS_MONO[AW-1:0]) || (a == OFS_CTRL[AW-1:0])  ||
             (a == OFS_GUARD[AW-1:0]);
   endfunction

   // bus-side write handshake
   logic          pend, done, apply;
   logic [AW-1:0] ap_addr;
   logic [31:0]   ap_data;
   logic          done_clr;

   assign done_clr = bus_we && (bus_addr == OFS_HSHK[AW-1:0]) && bus_wdata[HB_DONE];

   lprtc_wr_sync #(.AW(AW), .SYNC_TICKS(SYNC_TICKS)) i_sync (
      .clk, .rst_n, .slow_tick,
      .req      (bus_we && is_slow_reg(bus_addr)),
      .done_clr,
      .req_addr (bus_addr),
      .req_data (bus_wdata),
      .pend, .done, .apply, .ap_addr, .ap_data
   );

   logic ap_sec, ap_alarm, ap_mono, ap_ctrl, ap_guard;
   assign ap_sec   = apply && (ap_addr == OFS_SEC[AW-1:0]);
   assign ap_alarm = apply && (ap_addr == OFS_ALARM[AW-1:0]);
   assign ap_mono  = apply && (ap_addr == OFS_MONO[AW-1:0]);
   assign ap_ctrl  = apply && (ap_addr == OFS_CTRL[AW-1:0]);
   assign ap_guard = apply && (ap_addr == OFS_GUARD[AW-1:0]);

   // slow-side registers
   logic [31:0]       ctrl_q, alarm_q, guard_q;
   logic [MONO_W-1:0] mono_q;
   logic              guard_ok;

   assign guard_ok = (guard_q == GUARD_KEY);

   lp_state_e state;
   logic      init_exit_evt, nv_exit_evt;

   lprtc_fsm i_fsm (
      .clk, .rst_n,
      .ctrl_wr       (ap_ctrl),
      .req_init_exit (ap_data[CB_INX]),
      .req_nv_exit   (ap_data[CB_NVX]),
      .req_run       (ap_data[CB_RUN]),
      .guard_ok,
      .state, .init_exit_evt, .nv_exit_evt
   );

   logic [31:0]       secs;
   logic [FRAC_W-1:0] frac;
   logic              alarm_evt, twrap_evt;

   lprtc_timer #(.FRAC_W(FRAC_W)) i_timer (
      .clk, .rst_n,
      .advance    ((state == ST_VALID) && ctrl_q[CB_RUN] && slow_tick),
      .load       (ap_sec && !ctrl_q[CB_LOCKT]),
      .load_secs  (ap_data),
      .alarm_secs (alarm_q),
      .arm        (ctrl_q[CB_ARM]),
      .secs, .frac, .alarm_evt,
      .wrap_evt   (twrap_evt)
   );

   logic mono_inc, mwrap_evt;
   assign mono_inc  = ap_mono && !ctrl_q[CB_LOCKM];
   assign mwrap_evt = mono_inc && (&mono_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         alarm_q <= '0;
         guard_q <= '0;
         mono_q  <= '0;
      end else begin
         if (ap_ctrl)  ctrl_q  <= ap_data;
         if (ap_alarm) alarm_q <= ap_data;
         if (ap_guard) guard_q <= ap_data;
         if (mono_inc) mono_q  <= mono_q + MONO_W'(1);
      end
   end

   // sticky flags, write-one-to-clear
   logic stat_wr;
   logic f_alm, f_mwrap, f_twrap, f_nvx, f_inx;
   assign stat_wr = bus_we && (bus_addr == OFS_STAT[AW-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f_alm   <= 1'b0;
         f_mwrap <= 1'b0;
         f_twrap <= 1'b0;
         f_nvx   <= 1'b0;
         f_inx   <= 1'b0;
      end else begin
         f_alm   <= alarm_evt     | (f_alm   & ~(stat_wr & bus_wdata[SB_ALM]));
         f_mwrap <= mwrap_evt     | (f_mwrap & ~(stat_wr & bus_wdata[SB_MWRAP]));
         f_twrap <= twrap_evt     | (f_twrap & ~(stat_wr & bus_wdata[SB_TWRAP]));
         f_nvx   <= nv_exit_evt   | (f_nvx   & ~(stat_wr & bus_wdata[SB_NVX]));
         f_inx   <= init_exit_evt | (f_inx   & ~(stat_wr & bus_wdata[SB_INX]));
      end
   end

   assign irq = f_alm & ctrl_q[CB_IE];

   // read mux
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_SEC[AW-1:0]:   bus_rdata = secs;
         OFS_FRAC[AW-1:0]:  bus_rdata[31 -: FRAC_W] = frac;
         OFS_ALARM[AW-1:0]: bus_rdata = alarm_q;
         OFS_MONO[AW-1:0]:  bus_rdata = 32'(mono_q);
         OFS_CTRL[AW-1:0]:  bus_rdata = ctrl_q;
         OFS_STAT[AW-1:0]: begin
            bus_rdata[SB_NOKEY]          = !guard_ok;
            bus_rdata[SB_ALM]            = f_alm;
            bus_rdata[SB_MWRAP]          = f_mwrap;
            bus_rdata[SB_TWRAP]          = f_twrap;
            bus_rdata[SB_MODE+1:SB_MODE] = MODE_BITS;
            bus_rdata[SB_NVX]            = f_nvx;
            bus_rdata[SB_INX]            = f_inx;
         end
         OFS_GUARD[AW-1:0]: bus_rdata = guard_q;
         OFS_HSHK[AW-1:0]: begin
            bus_rdata[HB_PEND] = pend;
            bus_rdata[HB_DONE] = done;
         end
         default:           bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/lprtc_chk.sv
module lprtc_chk
   import lprtc_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        slow_tick,
   input logic        pend,
   input logic        done,
   input logic        ap_sec,
   input lp_state_e   state,
   input logic        guard_ok,
   input logic        irq,
   input logic        ie,
   input logic [31:0] secs
);
   // R5: a pending write only completes on a slow tick
   p_pend_ends_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend) |-> $past(slow_tick));

   // R5: a pending write survives every cycle without a tick
   p_pend_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !slow_tick) |=> pend);

   // R5: done rises together with the end of the wait
   p_done_with_apply_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $fell(pend));

   // R2: state moves only with the guard key present
   p_state_needs_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(state) |-> $past(guard_ok));

   // R4: valid state is never left
   p_valid_sticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_VALID) |=> (state == ST_VALID));

   // R4: time is frozen before the valid state, apart from loads
   p_frozen_before_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((state != ST_VALID) && !ap_sec) |=> $stable(secs));

   // R8: interrupt only with its enable
   p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ie);
endmodule

bind lprtc_top lprtc_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .slow_tick (slow_tick),
   .pend      (pend),
   .done      (done),
   .ap_sec    (ap_sec),
   .state     (state),
   .guard_ok  (guard_ok),
   .irq       (irq),
   .ie        (ctrl_q[7]),
   .secs      (secs)
);

// File: tb/test_lprtc_top.sv
`timescale 1ns/1ps
module test_lprtc_top;
   localparam int F    = 3;
   localparam int MW   = 4;
   localparam int SYNC = 3;
   localparam int MODE = 1;
   localparam logic [31:0] KEY = 32'h4173_6166;
   localparam longint MAXC = (longint'(1) << (32 + F)) - 1;
   localparam int     MAXM = (1 << MW) - 1;

   logic        clk = 0, rst_n = 0, slow_tick = 0, bus_we = 0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   lprtc_top #(.FRAC_W(F), .MONO_W(MW), .SYNC_TICKS(SYNC), .AW(6), .SEC_MODE(MODE))
      i_lprtc_top (.clk, .rst_n, .slow_tick, .bus_we, .bus_addr, .bus_wdata, .bus_rdata, .irq);

   always #2.5 clk = ~clk;

   int tdiv = 0;
   always @(posedge clk) begin
      #1;
      tdiv = tdiv + 1;
      slow_tick = (tdiv % 4 == 0);
   end

   // ---------------- behavioural reference ----------------
   longint      m_cnt;
   logic [31:0] m_alarm, m_guard, m_ctrl, m_pdata;
   int          m_mono, m_state, m_pcnt;
   logic [5:0]  m_paddr;
   bit          m_alm, m_mro, m_tro, m_inx, m_nvx, m_pend, m_done;

   function automatic bit slow_reg(input logic [5:0] a);
      return a == 6'h00 || a == 6'h08 || a == 6'h0C || a == 6'h10 || a == 6'h18;
   endfunction

   always @(posedge clk) begin
      bit ap, run, ld, aset, tset, mset, iset, nset;
      logic [31:0] clrw;
      if (!rst_n) begin
         m_cnt = 0; m_alarm = 0; m_guard = 0; m_ctrl = 0; m_mono = 0; m_state = 0;
         m_alm = 0; m_mro = 0; m_tro = 0; m_inx = 0; m_nvx = 0;
         m_pend = 0; m_done = 0; m_pcnt = 0; m_paddr = 0; m_pdata = 0;
      end else begin
         ap   = m_pend && slow_tick && (m_pcnt == SYNC - 1);
         run  = (m_state == 2) && m_ctrl[3] && slow_tick;
         ld   = ap && m_paddr == 6'h00 && !m_ctrl[8];
         clrw = (bus_we && bus_addr == 6'h14) ? bus_wdata : 32'h0;
         aset = 0; tset = 0; mset = 0; iset = 0; nset = 0;
         if (ld) m_cnt = longint'(m_pdata) << F;
         else if (run) begin
            if (m_cnt == MAXC) begin tset = 1; m_cnt = 0; end
            else m_cnt = m_cnt + 1;
            if (m_ctrl[4] && (m_cnt % (1 << F)) == 0 && (m_cnt >> F) == longint'(m_alarm))
               aset = 1;
         end
         if (ap && m_paddr == 6'h0C && !m_ctrl[9]) begin
            if (m_mono == MAXM) begin mset = 1; m_mono = 0; end
            else m_mono = m_mono + 1;
         end
         if (ap && m_paddr == 6'h10 && m_guard == KEY) begin
            if (m_state == 0 && m_pdata[15]) begin m_state = 1; iset = 1; end
            else if (m_state == 1 && m_pdata[14] && m_pdata[3]) begin m_state = 2; nset = 1; end
         end
         if (ap && m_paddr == 6'h08) m_alarm = m_pdata;
         if (ap && m_paddr == 6'h10) m_ctrl  = m_pdata;
         if (ap && m_paddr == 6'h18) m_guard = m_pdata;
         m_alm = aset | (m_alm & !clrw[3]);
         m_mro = mset | (m_mro & !clrw[4]);
         m_tro = tset | (m_tro & !clrw[5]);
         m_nvx = nset | (m_nvx & !clrw[14]);
         m_inx = iset | (m_inx & !clrw[15]);
         m_done = ap | (m_done & !(bus_we && bus_addr == 6'h1C && bus_wdata[19]));
         if (m_pend) begin
            if (slow_tick) begin
               if (ap) m_pend = 0;
               else m_pcnt = m_pcnt + 1;
            end
         end else if (bus_we && slow_reg(bus_addr)) begin
            m_pend = 1; m_pcnt = 0; m_paddr = bus_addr; m_pdata = bus_wdata;
         end
      end
   end

   function automatic logic [31:0] exp_rd(input logic [5:0] a);
      logic [31:0] v = 0;
      case (a)
         6'h00: v = 32'(m_cnt >> F);
         6'h04: v = 32'(m_cnt % (1 << F)) << (32 - F);
         6'h08: v = m_alarm;
         6'h0C: v = 32'(m_mono);
         6'h10: v = m_ctrl;
         6'h14: v = (32'(m_inx) << 15) | (32'(m_nvx) << 14) | (32'(MODE) << 10) |
                    (32'(m_tro) << 5) | (32'(m_mro) << 4) | (32'(m_alm) << 3) |
                    (32'(m_guard != KEY) << 1);
         6'h18: v = m_guard;
         6'h1C: v = (32'(m_pend) << 21) | (32'(m_done) << 19);
         default: v = 0;
      endcase
      return v;
   endfunction

   function automatic string req_of(input logic [5:0] a);
      case (a)
         6'h00, 6'h04: return "R4";
         6'h08: return "R8";
         6'h0C: return "R9";
         6'h10: return "R3";
         6'h14: return "R11";
         6'h18: return "R2";
         6'h1C: return "R5";
         default: return "R1";
      endcase
   endfunction

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         n_chk = n_chk + 1;
         if (bus_rdata !== exp_rd(bus_addr) || irq !== (m_alm && m_ctrl[7])) begin
            n_fail = n_fail + 1;
            $display("FAIL %s model compare @%0h: rdata %h irq %b expected %h %b",
                     req_of(bus_addr), bus_addr, bus_rdata, irq,
                     exp_rd(bus_addr), (m_alm && m_ctrl[7]));
         end
      end
   end

   // ---------------- directed stimulus ----------------
   logic irq_s;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk = n_chk + 1;
      if (got !== exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_we = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] v);
      @(posedge clk); #1;
      bus_we = 0; bus_addr = a;
      @(negedge clk);
      v = bus_rdata; irq_s = irq;
   endtask

   task automatic wait_sync();
      logic [31:0] v;
      for (int i = 0; i < 100; i++) begin
         rd(6'h1C, v);
         if (!v[21]) break;
      end
   endtask

   task automatic wsync(input logic [5:0] a, input logic [31:0] d);
      wr(a, d);
      wait_sync();
   endtask

   initial begin
      logic [31:0] v, s;
      repeat (4) @(posedge clk);
      #1 rst_n = 1;

      rd(6'h14, v); chk("R1 status after reset", v, 32'h0000_0402);
      chk("R1 irq after reset", {31'b0, irq_s}, 0);
      rd(6'h00, v); chk("R1 seconds after reset", v, 0);

      wsync(6'h10, 32'h8000);
      rd(6'h14, v); chk("R2 init exit ignored without key", v, 32'h0000_0402);
      wsync(6'h18, KEY);
      rd(6'h14, v); chk("R2 key clears bit 1", v, 32'h0000_0400);

      wsync(6'h10, 32'h8000);
      rd(6'h14, v); chk("R3 init exit flag", v, 32'h0000_8400);

      wsync(6'h00, 32'd5);
      repeat (40) @(posedge clk);
      rd(6'h04, v); chk("R4 fraction frozen before valid", v, 0);
      rd(6'h00, v); chk("R4 seconds frozen before valid", v, 5);

      wsync(6'h10, 32'h0000_C008);
      rd(6'h14, v); chk("R4 non-valid exit flag", v, 32'h0000_C400);
      repeat (48) @(posedge clk);
      rd(6'h00, v); chk("R4 counter runs in valid", {31'b0, v > 5}, 1);

      wr(6'h08, 32'h55);
      wr(6'h08, 32'h66);
      rd(6'h1C, v); chk("R5 pending bit while waiting", {31'b0, v[21]}, 1);
      wait_sync();
      rd(6'h08, v); chk("R6 second write dropped", v, 32'h55);
      rd(6'h1C, v); chk("R5 done bit after sync", v, 32'h0008_0000);
      wr(6'h1C, 32'h0008_0000);
      rd(6'h1C, v); chk("R5 done bit cleared", v, 0);

      rd(6'h00, s);
      wsync(6'h08, s + 4);
      wsync(6'h10, 32'h0000_0098);
      for (int i = 0; i < 400; i++) begin
         rd(6'h14, v);
         if (irq_s) break;
      end
      chk("R8 irq raised on alarm", {31'b0, irq_s}, 1);
      chk("R8 alarm flag", {31'b0, v[3]}, 1);
      rd(6'h00, v); chk("R8 alarm second", v, s + 4);
      wr(6'h14, 32'h8);
      rd(6'h14, v); chk("R11 alarm flag cleared", {31'b0, v[3]}, 0);
      chk("R8 irq falls with flag", {31'b0, irq_s}, 0);

      wsync(6'h00, 32'h100);
      rd(6'h00, v); chk("R7 seconds loaded", v, 32'h100);
      rd(6'h04, v); chk("R7 fraction cleared on load", {31'b0, v[31:29] <= 1}, 1);
      wsync(6'h10, 32'h0000_0198);
      wsync(6'h00, 32'd7);
      rd(6'h00, v); chk("R7 load ignored while locked", v, 32'h100);

      wsync(6'h10, 32'h0000_0098);
      for (int i = 0; i < MAXM; i++) wsync(6'h0C, 0);
      rd(6'h0C, v); chk("R9 monotonic count", v, MAXM);
      rd(6'h14, v); chk("R9 no wrap flag yet", {31'b0, v[4]}, 0);
      wsync(6'h0C, 0);
      rd(6'h0C, v); chk("R9 monotonic wraps", v, 0);
      rd(6'h14, v); chk("R9 wrap flag", {31'b0, v[4]}, 1);
      wsync(6'h10, 32'h0000_0298);
      wsync(6'h0C, 0);
      rd(6'h0C, v); chk("R9 increment ignored while locked", v, 0);

      wsync(6'h10, 32'h0000_0008);
      wsync(6'h00, 32'hFFFF_FFFF);
      for (int i = 0; i < 200; i++) begin
         rd(6'h14, v);
         if (v[5]) break;
      end
      chk("R10 time wrap flag", {31'b0, v[5]}, 1);
      rd(6'h00, v); chk("R10 seconds after wrap", v, 0);

      wr(6'h14, 32'hFFFF_FFFF);
      rd(6'h14, v); chk("R11 all flags cleared", v, 32'h0000_0400);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk = n_chk + 1;
         n_fail = n_fail + 1;
         $display("FAIL R5 watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule